// File: doc/BRIEF.md
# Sequential Vector Coprocessor Unit

This block adds a small vector extension beside an 8-bit microcontroller datapath. It holds three vector banks, V1, V2 and V3, each of eight byte-wide elements. It executes five instructions: load a bank from memory, store a bank to memory, and element-wise add, subtract and multiply. Arithmetic always reads V1 and V2 and always writes V3.

Every instruction walks the vector one element per clock. Loads and stores move bytes over a single-port byte memory, starting at a 16-bit base address that the host supplies from one of its scalar registers. The host pulses a start strobe with an opcode, a bank code and the base address. It then watches a busy level and a one-cycle done pulse. The vector banks are reached only through loads and stores.

Top module: `vec_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are low.
- R2: Opcode codes are 0 load, 1 store, 2 add, 3 subtract and 4 multiply. Bank codes are 0 for V1, 1 for V2 and 2 for V3. A start seen while idle raises `busy_o` in the next cycle, and `busy_o` stays high for exactly eight cycles.
- R3: `done_o` is high for exactly one cycle: the cycle right after the last busy cycle.
- R4: In busy cycle k (k = 0..7), a load drives `mem_rd_o` high with address base+k. It writes the byte returned on `mem_rdata_i` in the following cycle into element k of the selected bank.
- R5: In busy cycle k, a store drives `mem_wr_o` high with address base+k and data equal to element k of the selected bank.
- R6: Add writes V3[k] = (V1[k] + V2[k]) mod 256 for every element.
- R7: Subtract writes V3[k] = (V1[k] - V2[k]) mod 256 for every element.
- R8: Multiply writes V3[k] = the low 8 bits of V1[k] * V2[k] for every element.
- R9: Memory addresses wrap modulo 65536, so base 0xFFFC reaches 0xFFFF and then 0x0000.
- R10: A start seen while `busy_o` is high is ignored. The running instruction is not lengthened or altered, and no access is made for the ignored request.
- R11: Opcodes 5 to 7 are ignored, and so are load or store with bank code 3. `busy_o` stays low and no memory access occurs.
- R12: `mem_rd_o` and `mem_wr_o` are never high together, and neither is high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch strobe, sampled only when idle |
| opcode_i | input | 3 | Instruction code |
| bank_i | input | 2 | Bank code for load and store |
| base_i | input | 16 | Base address from the host scalar register |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read request; data returns one cycle later |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets arithmetic that overflows, underflows and truncates a product. A unit that kept carry or borrow bits, or the high product byte, would store wrong bytes.

It checks load capture timing by starting a store of the just-loaded bank in the done cycle itself. A unit that wrote the last element late, or with the wrong index, would store a stale byte.

A store at base 0xFFFC shows whether the address wraps or spills into a wider sum. A second start is pulsed mid-instruction, and reserved codes are issued. A unit that honoured any of these would issue reads or change the busy length.

// File: rtl/vec_pkg.sv
// Shared opcode and bank encodings for the vector unit.
// Assumes a 3-bit opcode and a 2-bit bank code.
package vec_pkg;
    typedef enum logic [2:0] {
        VOP_LOAD  = 3'd0,
        VOP_STORE = 3'd1,
        VOP_ADD   = 3'd2,
        VOP_SUB   = 3'd3,
        VOP_MUL   = 3'd4
    } vop_e;

    localparam int NUM_BANKS = 3;
    localparam int BANK_W    = 2;
    localparam logic [BANK_W-1:0] BANK_DST = 2'd2;
endpackage

// File: rtl/vec_seq.sv
// Element sequencer: accepts a start when idle, walks the element index
// and produces busy/done plus the load-capture pipeline stage.
// Assumes memory read data returns exactly one cycle after the request.
module vec_seq
    import vec_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_ELEM = 8,
    localparam int IDX_W   = $clog2(NUM_ELEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        opcode_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  idx_o,
    output vop_e              op_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              cap_vld_o,
    output logic [IDX_W-1:0]  cap_idx_o,
    output logic [BANK_W-1:0] cap_bank_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEM - 1);

    logic req_ok;
    logic accept;

    // Decide whether the requested opcode and bank form a legal instruction.
    always_comb begin
        unique case (opcode_i)
            VOP_LOAD, VOP_STORE: req_ok = (bank_i < BANK_W'(NUM_BANKS));
            VOP_ADD, VOP_SUB, VOP_MUL: req_ok = 1'b1;
            default: req_ok = 1'b0;
        endcase
    end

    assign accept = start_i && !busy_o && req_ok;

    // Run state: latch the instruction on accept and step the element index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            idx_o  <= '0;
            op_o   <= VOP_LOAD;
            bank_o <= '0;
            base_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                busy_o <= 1'b1;
                idx_o  <= '0;
                op_o   <= vop_e'(opcode_i);
                bank_o <= bank_i;
                base_o <= base_i;
            end else if (busy_o) begin
                if (idx_o == LAST_IDX) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    idx_o <= idx_o + 1'b1;
                end
            end
        end
    end

    // Load capture stage: remember which element the returning byte belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld_o  <= 1'b0;
            cap_idx_o  <= '0;
            cap_bank_o <= '0;
        end else begin
            cap_vld_o  <= busy_o && (op_o == VOP_LOAD);
            cap_idx_o  <= idx_o;
            cap_bank_o <= bank_o;
        end
    end
endmodule

// File: rtl/vec_regfile.sv
// Three vector banks with one write port, the two fixed arithmetic
// source reads (bank 0 and bank 1) and one selectable read.
// Assumes the write index and the bank code are in range.
module vec_regfile
    import vec_pkg::*;
#(
    parameter int ELEM_W   = 8,
    parameter int NUM_ELEM = 8,
    localparam int IDX_W   = $clog2(NUM_ELEM)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [BANK_W-1:0] wr_bank_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ELEM_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [BANK_W-1:0] rd_bank_i,
    output logic [ELEM_W-1:0] src_a_o,
    output logic [ELEM_W-1:0] src_b_o,
    output logic [ELEM_W-1:0] sel_o
);
    logic [ELEM_W-1:0] rd_elem [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ELEM_W-1:0] cells [NUM_ELEM];

        // Element storage for one bank, written when this bank is addressed.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_bank_i == BANK_W'(b))) begin
                cells[wr_idx_i] <= wr_data_i;
            end
        end

        assign rd_elem[b] = cells[rd_idx_i];
    end

    assign src_a_o = rd_elem[0];
    assign src_b_o = rd_elem[1];

    // Selectable read for stores; codes outside the bank range read zero.
    always_comb begin
        sel_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank_i == BANK_W'(b)) sel_o = rd_elem[b];
        end
    end
endmodule

// File: rtl/vec_alu.sv
// Element ALU: wrapping add and subtract, multiply keeping the low half.
// Purely combinational; non-arithmetic opcodes yield zero.
module vec_alu
    import vec_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  vop_e              op_i,
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    output logic [ELEM_W-1:0] y_o
);
    logic [2*ELEM_W-1:0] prod;

    assign prod = {{ELEM_W{1'b0}}, a_i} * {{ELEM_W{1'b0}}, b_i};

    // Select the element result for the current opcode.
    always_comb begin
        unique case (op_i)
            VOP_ADD: y_o = a_i + b_i;
            VOP_SUB: y_o = a_i - b_i;
            VOP_MUL: y_o = prod[ELEM_W-1:0];
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/vec_unit.sv
// Top of the sequential vector unit. It ties the sequencer, the banks and
// the ALU together and drives the single-port byte memory interface.
// Assumes a memory with one-cycle read latency and single-cycle writes.
module vec_unit
    import vec_pkg::*;
#(
    parameter int ELEM_W   = 8,
    parameter int ADDR_W   = 16,
    parameter int NUM_ELEM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        opcode_i,
    input  logic [1:0]        bank_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ELEM_W-1:0] mem_wdata_o,
    input  logic [ELEM_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o
);
    localparam int IDX_W = $clog2(NUM_ELEM);

    logic [IDX_W-1:0]  idx;
    vop_e              op_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] base_q;
    logic              cap_vld;
    logic [IDX_W-1:0]  cap_idx;
    logic [BANK_W-1:0] cap_bank;
    logic              wr_en;
    logic [BANK_W-1:0] wr_bank;
    logic [IDX_W-1:0]  wr_idx;
    logic [ELEM_W-1:0] wr_data;
    logic [ELEM_W-1:0] src_a;
    logic [ELEM_W-1:0] src_b;
    logic [ELEM_W-1:0] sel_elem;
    logic [ELEM_W-1:0] alu_y;
    logic              is_arith;

    vec_seq #(
        .ADDR_W   (ADDR_W),
        .NUM_ELEM (NUM_ELEM)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .opcode_i   (opcode_i),
        .bank_i     (bank_i),
        .base_i     (base_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .idx_o      (idx),
        .op_o       (op_q),
        .bank_o     (bank_q),
        .base_o     (base_q),
        .cap_vld_o  (cap_vld),
        .cap_idx_o  (cap_idx),
        .cap_bank_o (cap_bank)
    );

    vec_regfile #(
        .ELEM_W   (ELEM_W),
        .NUM_ELEM (NUM_ELEM)
    ) u_rf (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_bank_i (wr_bank),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (idx),
        .rd_bank_i (bank_q),
        .src_a_o   (src_a),
        .src_b_o   (src_b),
        .sel_o     (sel_elem)
    );

    vec_alu #(
        .ELEM_W (ELEM_W)
    ) u_alu (
        .op_i (op_q),
        .a_i  (src_a),
        .b_i  (src_b),
        .y_o  (alu_y)
    );

    assign is_arith = (op_q == VOP_ADD) || (op_q == VOP_SUB) || (op_q == VOP_MUL);

    // Memory side: one access per busy cycle, the address stepping from the base.
    assign mem_addr_o  = base_q + ADDR_W'(idx);
    assign mem_rd_o    = busy_o && (op_q == VOP_LOAD);
    assign mem_wr_o    = busy_o && (op_q == VOP_STORE);
    assign mem_wdata_o = sel_elem;

    // Bank write port: load capture takes priority over the arithmetic result.
    always_comb begin
        wr_en   = 1'b0;
        wr_bank = BANK_DST;
        wr_idx  = idx;
        wr_data = alu_y;
        if (cap_vld) begin
            wr_en   = 1'b1;
            wr_bank = cap_bank;
            wr_idx  = cap_idx;
            wr_data = mem_rdata_i;
        end else if (busy_o && is_arith) begin
            wr_en = 1'b1;
        end
    end
endmodule

// File: rtl/vec_unit_chk.sv
// Protocol checker for vec_unit, attached by bind. It watches only the ports
// and counts busy run length in its own register.
module vec_unit_chk #(
    parameter int ADDR_W   = 16,
    parameter int NUM_ELEM = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    int unsigned run_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= 0;
        else if (busy_o) run_len <= run_len + 1;
        else             run_len <= 0;
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o)); // R1

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_len < NUM_ELEM)); // R2

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (mem_rd_o || mem_wr_o))
            |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))); // R9

    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R12

    AST_NO_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> busy_o); // R12
endmodule

bind vec_unit vec_unit_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_ELEM (NUM_ELEM)
) u_vec_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/test_vec_unit.sv
`timescale 1ns/1ps
module test_vec_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [2:0]  opcode_i;
    logic [1:0]  bank_i;
    logic [15:0] base_i;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o;
    logic        mem_wr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i;
    logic        busy_o;
    logic        done_o;

    int tests = 0;
    int fails = 0;

    logic [7:0]  bmem [256];
    logic [15:0] acc_addr [32];
    logic        acc_wr [32];
    int          nacc = 0;
    int          idle_acc = 0;

    always #2.5 clk = ~clk;

    vec_unit i_vec_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .bank_i(bank_i), .base_i(base_i), .mem_addr_o(mem_addr_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o)
    );

    // Byte memory model: one-cycle read latency, low 8 address bits decoded.
    always @(posedge clk) begin
        if (mem_wr_o) bmem[mem_addr_o[7:0]] <= mem_wdata_o;
        if (mem_rd_o) mem_rdata_i <= bmem[mem_addr_o[7:0]];
    end

    // Access logger, sampled mid-cycle.
    always @(negedge clk) begin
        if (mem_rd_o || mem_wr_o) begin
            if (!busy_o) idle_acc++;
            if (nacc < 32) begin
                acc_addr[nacc] = mem_addr_o;
                acc_wr[nacc]   = mem_wr_o;
            end
            nacc++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [2:0] op, input logic [1:0] bk, input logic [15:0] base);
        @(negedge clk);
        start_i = 1'b1; opcode_i = op; bank_i = bk; base_i = base;
        nacc = 0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_op(input int pre);
        int n = pre;
        while (busy_o && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk(n == 8, "R2 busy length", n, 8);
        chk(done_o == 1'b1, "R3 done after busy", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R3 done single cycle", done_o, 0);
    endtask

    task automatic run(input logic [2:0] op, input logic [1:0] bk, input logic [15:0] base);
        launch(op, bk, base);
        finish_op(0);
    endtask

    task automatic fill(input logic [7:0] addr, input logic [7:0] v [8]);
        for (int k = 0; k < 8; k++) bmem[8'(addr + k)] = v[k];
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start_i = 1'b0; opcode_i = '0; bank_i = '0; base_i = '0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_rd_o && !mem_wr_o, "R1 reset idle",
            {busy_o, done_o, mem_rd_o, mem_wr_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_load_store();
        logic [7:0] a [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
        bit ok = 1'b1;
        fill(8'h10, a);
        run(3'd0, 2'd0, 16'h0010);
        for (int k = 0; k < 8; k++)
            if (acc_addr[k] != 16'h0010 + 16'(k) || acc_wr[k]) ok = 1'b0;
        chk(ok && nacc == 8, "R4 load read addresses", nacc, 8);
        run(3'd1, 2'd0, 16'h0060);
        ok = 1'b1;
        for (int k = 0; k < 8; k++)
            if (!acc_wr[k] || acc_addr[k] != 16'h0060 + 16'(k)) ok = 1'b0;
        chk(ok && nacc == 8, "R5 store write addresses", nacc, 8);
        for (int k = 0; k < 8; k++)
            chk(bmem[8'h60 + k] == a[k], "R4 R5 load then store data", bmem[8'h60 + k], a[k]);
    endtask

    task automatic t_arith(input logic [2:0] op, input string req,
                           input logic [7:0] a [8], input logic [7:0] b [8]);
        logic [7:0] e;
        fill(8'h10, a);
        fill(8'h20, b);
        run(3'd0, 2'd0, 16'h0010);
        run(3'd0, 2'd1, 16'h0020);
        run(op, 2'd3, 16'h0000);
        chk(nacc == 0, {req, " no memory access"}, nacc, 0);
        run(3'd1, 2'd2, 16'h0040);
        for (int k = 0; k < 8; k++) begin
            case (op)
                3'd2: e = 8'((int'(a[k]) + int'(b[k])) % 256);
                3'd3: e = 8'((int'(a[k]) - int'(b[k]) + 256) % 256);
                default: e = 8'((int'(a[k]) * int'(b[k])) % 256);
            endcase
            chk(bmem[8'h40 + k] == e, req, bmem[8'h40 + k], e);
        end
    endtask

    task automatic t_back_to_back();
        logic [7:0] c [8] = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hF7};
        int n = 0;
        fill(8'h30, c);
        launch(3'd0, 2'd1, 16'h0030);
        while (busy_o && n < 20) begin n++; @(negedge clk); end
        start_i = 1'b1; opcode_i = 3'd1; bank_i = 2'd1; base_i = 16'h0070;
        @(negedge clk);
        start_i = 1'b0;
        nacc = 0;
        finish_op(0);
        for (int k = 0; k < 8; k++)
            chk(bmem[8'h70 + k] == c[k], "R4 capture before back-to-back store",
                bmem[8'h70 + k], c[k]);
    endtask

    task automatic t_ignore_busy();
        int rd = 0;
        launch(3'd1, 2'd0, 16'h0080);
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b1; opcode_i = 3'd0; bank_i = 2'd0; base_i = 16'h0010;
        @(negedge clk);
        start_i = 1'b0;
        finish_op(3);
        for (int k = 0; k < 8 && k < nacc; k++) if (!acc_wr[k]) rd++;
        chk(nacc == 8 && rd == 0, "R10 start while busy ignored", nacc * 100 + rd, 800);
        chk(bmem[8'h87] == 8'h88, "R10 running store unchanged", bmem[8'h87], 8'h88);
    endtask

    task automatic t_reserved();
        for (int op = 5; op < 8; op++) begin
            @(negedge clk);
            start_i = 1'b1; opcode_i = 3'(op); bank_i = 2'd0; base_i = 16'h0010;
            nacc = 0;
            @(negedge clk);
            start_i = 1'b0;
            repeat (3) @(negedge clk);
            chk(!busy_o && !done_o && nacc == 0, "R11 reserved opcode ignored",
                nacc + int'(busy_o), 0);
        end
        for (int op = 0; op < 2; op++) begin
            @(negedge clk);
            start_i = 1'b1; opcode_i = 3'(op); bank_i = 2'd3; base_i = 16'h0010;
            nacc = 0;
            @(negedge clk);
            start_i = 1'b0;
            repeat (3) @(negedge clk);
            chk(!busy_o && nacc == 0, "R11 bank code 3 ignored", nacc + int'(busy_o), 0);
        end
    endtask

    task automatic t_wrap();
        bit ok = 1'b1;
        run(3'd1, 2'd0, 16'hFFFC);
        for (int k = 0; k < 8; k++)
            if (acc_addr[k] != 16'(32'hFFFC + k)) ok = 1'b0;
        chk(ok, "R9 address wrap", acc_addr[4], 0);
        chk(bmem[8'h01] == 8'h66, "R9 wrapped store data", bmem[8'h01], 8'h66);
    endtask

    initial begin
        t_reset();
        t_load_store();
        t_arith(3'd2, "R6 add wraps",
            '{8'd200, 8'd255, 8'd1, 8'd128, 8'd0, 8'd100, 8'd17, 8'd250},
            '{8'd100, 8'd1, 8'd2, 8'd128, 8'd0, 8'd155, 8'd3, 8'd10});
        t_arith(3'd3, "R7 subtract wraps",
            '{8'd5, 8'd0, 8'd200, 8'd128, 8'd9, 8'd255, 8'd1, 8'd50},
            '{8'd10, 8'd1, 8'd100, 8'd129, 8'd9, 8'd0, 8'd255, 8'd49});
        t_arith(3'd4, "R8 multiply low byte",
            '{8'd16, 8'd255, 8'd3, 8'd0, 8'd128, 8'd15, 8'd200, 8'd1},
            '{8'd16, 8'd255, 8'd7, 8'd99, 8'd2, 8'd17, 8'd200, 8'd1});
        t_load_store();
        t_back_to_back();
        t_ignore_busy();
        t_reserved();
        t_wrap();
        chk(idle_acc == 0, "R12 no access while idle", idle_acc, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule